// File: doc/BRIEF.md
# Type-B Reader Frame Serializer

This block turns a stream of command bytes into the bit sequence a proximity reader sends to a type-B tag. Bytes arrive on a valid/ready byte port, the final byte of a command carries a last marker, and the bytes already include their checksum. Each bit lasts one period of an external bit tick. For every frame the block emits a start-of-frame marker, one framed character per byte, an end-of-frame marker and a run of trailing ones.

The output drives the modulator directly and is the inverse of the logical bit. A logical 1, which is the line's rest level, gives an output of 0 and leaves the carrier on. A logical 0 gives an output of 1 and modulates the carrier. When nothing is being sent, the output therefore holds the carrier on.

A new byte is taken while the block is idle, while it sends the stop bit of a character that is not the last, or while it waits for a late byte. If the next byte is late, the line stays at the rest level until the byte arrives. A busy flag covers the whole frame, and a one-clock done pulse closes it.

Top module: `tbx_frame_serializer`

## Requirements
- R1: After reset, and at any time frame_busy is low, mod_out is 0 (carrier on). Right after reset, cmd_ready is 1, frame_busy is 0 and frame_done is 0.
- R2: mod_out is the inverse of the logical bit being sent: a logical 0 gives mod_out = 1, and a logical 1 gives mod_out = 0.
- R3: Each frame opens with 10 logical zeros followed by 2 logical ones. No rest-level ones are sent before it. The first zero is driven at the first bit_tick at or after the handshake of the frame's first byte.
- R4: Each byte is sent as one character of ten bits: a logical 0 start bit, then the eight data bits with cmd_byte[0] first and cmd_byte[7] last, then one logical 1 stop bit.
- R5: If the next byte has been handshaken by the bit_tick that ends a stop bit, the next start bit follows that stop bit directly, with no idle bit between them.
- R6: cmd_ready is 1 only when no byte is held and one of these is true: the block is idle, it is driving the stop bit of a character that is not the last, or it is waiting for a late byte. cmd_ready is 0 during start-of-frame bits, start bits, data bits, the last character's stop bit, end-of-frame bits and trailing bits. Apart from a handshake, cmd_ready changes only at a bit_tick edge.
- R7: If a non-last character ends and no byte is available, the block sends one logical 1 per bit_tick until a byte is handshaken.
- R8: After the stop bit of the character marked last, the block sends 10 logical zeros and then one logical 1.
- R9: After that end-of-frame marker, the block sends 8 more logical ones.
- R10: frame_done is high for exactly one clock. The pulse comes at the bit_tick that follows the final trailing bit, and frame_busy is 0 from that same clock.
- R11: mod_out changes only in the clock that follows a clock edge at which bit_tick was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-clock pulse that marks each bit boundary |
| cmd_valid | input | 1 | A command byte is offered |
| cmd_byte | input | DATA_W | Command byte, checksum included |
| cmd_last | input | 1 | Marks the final byte of the frame |
| cmd_ready | output | 1 | The block takes the offered byte at this edge |
| mod_out | output | 1 | Modulation control, the inverse of the logical bit |
| frame_busy | output | 1 | High from byte acceptance until the done pulse |
| frame_done | output | 1 | One-clock pulse that closes a frame |

## Verification
The embedded properties treat bit_tick as the only event that moves the framing forward. They assume the byte source marks the final byte of every frame with cmd_last, because without that marker the block stays in the late-byte wait and never closes the frame. The stimulus meets these assumptions: a single negedge process raises bit_tick as a one-clock pulse every fourth clock, cmd_valid and the byte fields change only at falling edges, and every frame marks its last byte. One frame holds back its second byte so that the late-byte wait is exercised with the byte source still behaving correctly.

// File: rtl/tbx_ser_pkg.sv
package tbx_ser_pkg;

    // Default framing counts and data width
    localparam int unsigned DEF_DATA_W    = 8;
    localparam int unsigned DEF_SOF_ZEROS = 10;
    localparam int unsigned DEF_SOF_ONES  = 2;
    localparam int unsigned DEF_EOF_ZEROS = 10;
    localparam int unsigned DEF_EOF_ONES  = 1;
    localparam int unsigned DEF_PAD_ONES  = 8;

    // Which section of the frame the sequencer is currently driving
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ARMED,
        PH_SOF,
        PH_CHAR,
        PH_GAP,
        PH_EOF,
        PH_PAD
    } phase_e;

    // Request from the sequencer to the line register
    typedef struct packed {
        logic fire;   // drive a new bit this tick
        logic level;  // logical level of that bit
        logic fin;    // frame closes at this tick
    } emit_t;

    function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned width_for(int unsigned top_value);
        return (top_value < 2) ? 1 : $clog2(top_value + 1);
    endfunction

endpackage

// File: rtl/tbx_byte_stage.sv
module tbx_byte_stage #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              cmd_last,
    output logic              cmd_ready,
    input  logic              open_win,
    input  logic              take,
    output logic              avail,
    output logic [DATA_W-1:0] avail_byte,
    output logic              avail_last
);

    logic              full_q;
    logic [DATA_W-1:0] byte_q;
    logic              last_q;
    logic              fire;

    assign cmd_ready  = open_win && !full_q;
    assign fire       = cmd_valid && cmd_ready;
    // A byte handed over at the same edge as it is consumed bypasses the holder
    assign avail      = full_q || fire;
    assign avail_byte = full_q ? byte_q : cmd_byte;
    assign avail_last = full_q ? last_q : cmd_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            byte_q <= '0;
            last_q <= 1'b0;
        end else if (take) begin
            full_q <= 1'b0;
        end else if (fire) begin
            full_q <= 1'b1;
            byte_q <= cmd_byte;
            last_q <= cmd_last;
        end
    end

    // R5: the sequencer only consumes a byte that exists
    p_take_has_byte_r5 : assert property (@(posedge clk) disable iff (rst)
        take |-> avail)
        else $error("p_take_has_byte_r5");

    // R6: a held byte stays until it is consumed
    p_hold_until_take_r6 : assert property (@(posedge clk) disable iff (rst)
        (full_q && !take) |=> full_q)
        else $error("p_hold_until_take_r6");

endmodule

// File: rtl/tbx_bit_sequencer.sv
module tbx_bit_sequencer
    import tbx_ser_pkg::*;
#(
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned SOF_ZEROS = DEF_SOF_ZEROS,
    parameter int unsigned SOF_ONES  = DEF_SOF_ONES,
    parameter int unsigned EOF_ZEROS = DEF_EOF_ZEROS,
    parameter int unsigned EOF_ONES  = DEF_EOF_ONES,
    parameter int unsigned PAD_ONES  = DEF_PAD_ONES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              avail,
    input  logic [DATA_W-1:0] avail_byte,
    input  logic              avail_last,
    output logic              open_win,
    output logic              take,
    output emit_t             emit,
    output logic              frame_busy
);

    localparam int unsigned SOF_LEN  = SOF_ZEROS + SOF_ONES;
    localparam int unsigned CHAR_LEN = DATA_W + 2;
    localparam int unsigned EOF_LEN  = EOF_ZEROS + EOF_ONES;
    localparam int unsigned CNT_MAX  = max_of3(SOF_LEN, CHAR_LEN, max_of3(EOF_LEN, PAD_ONES, 1));
    localparam int unsigned CNT_W    = width_for(CNT_MAX);

    localparam logic [CNT_W-1:0] C_SOF_END  = CNT_W'(SOF_LEN - 1);
    localparam logic [CNT_W-1:0] C_SOF_Z    = CNT_W'(SOF_ZEROS);
    localparam logic [CNT_W-1:0] C_STOP     = CNT_W'(CHAR_LEN - 1);
    localparam logic [CNT_W-1:0] C_LAST_DAT = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] C_EOF_END  = CNT_W'(EOF_LEN - 1);
    localparam logic [CNT_W-1:0] C_EOF_Z    = CNT_W'(EOF_ZEROS);
    localparam logic [CNT_W-1:0] C_PAD_END  = CNT_W'(PAD_ONES - 1);

    phase_e            phase_q, phase_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_nx;
    logic [DATA_W-1:0] shift_q, shift_d;
    logic              last_q, last_d;
    logic              begin_char;

    assign cnt_nx     = cnt_q + 1'b1;
    assign frame_busy = (phase_q != PH_IDLE);
    assign open_win   = (phase_q == PH_IDLE) || (phase_q == PH_GAP) ||
                        ((phase_q == PH_CHAR) && (cnt_q == C_STOP) && !last_q);

    always_comb begin
        phase_d    = phase_q;
        cnt_d      = cnt_q;
        shift_d    = shift_q;
        last_d     = last_q;
        take       = 1'b0;
        emit       = '0;
        begin_char = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (avail) begin
                    if (bit_tick) begin
                        phase_d    = PH_SOF;
                        cnt_d      = '0;
                        emit.fire  = 1'b1;
                        emit.level = 1'b0;
                    end else begin
                        phase_d = PH_ARMED;
                    end
                end
            end
            PH_ARMED: begin
                if (bit_tick) begin
                    phase_d    = PH_SOF;
                    cnt_d      = '0;
                    emit.fire  = 1'b1;
                    emit.level = 1'b0;
                end
            end
            PH_SOF: begin
                if (bit_tick) begin
                    if (cnt_q == C_SOF_END) begin
                        begin_char = 1'b1;
                    end else begin
                        cnt_d      = cnt_nx;
                        emit.fire  = 1'b1;
                        emit.level = (cnt_nx >= C_SOF_Z);
                    end
                end
            end
            PH_CHAR: begin
                if (bit_tick) begin
                    if (cnt_q == C_STOP) begin
                        if (last_q) begin
                            phase_d    = PH_EOF;
                            cnt_d      = '0;
                            emit.fire  = 1'b1;
                            emit.level = (EOF_ZEROS == 0);
                        end else if (avail) begin
                            begin_char = 1'b1;
                        end else begin
                            phase_d    = PH_GAP;
                            emit.fire  = 1'b1;
                            emit.level = 1'b1;
                        end
                    end else begin
                        cnt_d     = cnt_nx;
                        emit.fire = 1'b1;
                        if (cnt_q == C_LAST_DAT) begin
                            emit.level = 1'b1;
                        end else begin
                            emit.level = shift_q[0];
                            shift_d    = {1'b0, shift_q[DATA_W-1:1]};
                        end
                    end
                end
            end
            PH_GAP: begin
                if (bit_tick) begin
                    if (avail) begin
                        begin_char = 1'b1;
                    end else begin
                        emit.fire  = 1'b1;
                        emit.level = 1'b1;
                    end
                end
            end
            PH_EOF: begin
                if (bit_tick) begin
                    emit.fire = 1'b1;
                    if (cnt_q == C_EOF_END) begin
                        phase_d    = PH_PAD;
                        cnt_d      = '0;
                        emit.level = 1'b1;
                    end else begin
                        cnt_d      = cnt_nx;
                        emit.level = (cnt_nx >= C_EOF_Z);
                    end
                end
            end
            PH_PAD: begin
                if (bit_tick) begin
                    if (cnt_q == C_PAD_END) begin
                        phase_d  = PH_IDLE;
                        cnt_d    = '0;
                        emit.fin = 1'b1;
                    end else begin
                        cnt_d      = cnt_nx;
                        emit.fire  = 1'b1;
                        emit.level = 1'b1;
                    end
                end
            end
            default: phase_d = PH_IDLE;
        endcase

        if (begin_char) begin
            take       = 1'b1;
            shift_d    = avail_byte;
            last_d     = avail_last;
            phase_d    = PH_CHAR;
            cnt_d      = '0;
            emit.fire  = 1'b1;
            emit.level = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            shift_q <= '0;
            last_q  <= 1'b0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
            shift_q <= shift_d;
            last_q  <= last_d;
        end
    end

    // R11: bits are only produced at a tick
    p_emit_on_tick_r11 : assert property (@(posedge clk) disable iff (rst)
        emit.fire |-> bit_tick)
        else $error("p_emit_on_tick_r11");

    // R10: the frame only closes out of the trailing-ones section
    p_close_from_pad_r10 : assert property (@(posedge clk) disable iff (rst)
        emit.fin |=> !frame_busy && $past(phase_q == PH_PAD))
        else $error("p_close_from_pad_r10");

    // R8: the last character is followed by the end-of-frame marker
    p_last_leads_eof_r8 : assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_CHAR && cnt_q == C_STOP && last_q && bit_tick) |=> (phase_q == PH_EOF))
        else $error("p_last_leads_eof_r8");

endmodule

// File: rtl/tbx_line_drive.sv
module tbx_line_drive
    import tbx_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  emit_t emit,
    output logic  mod_out,
    output logic  frame_done
);

    logic mod_q;
    logic done_q;

    // The register holds the inverted level so rest (logical 1) means carrier on
    always_ff @(posedge clk) begin
        if (rst) begin
            mod_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (emit.fire) begin
                mod_q <= ~emit.level;
            end
            done_q <= emit.fin;
        end
    end

    assign mod_out    = mod_q;
    assign frame_done = done_q;

    // R10: the done pulse lasts one clock
    p_done_single_r10 : assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done)
        else $error("p_done_single_r10");

endmodule

// File: rtl/tbx_frame_serializer.sv
module tbx_frame_serializer
    import tbx_ser_pkg::*;
#(
    parameter int unsigned DATA_W    = DEF_DATA_W,
    parameter int unsigned SOF_ZEROS = DEF_SOF_ZEROS,
    parameter int unsigned SOF_ONES  = DEF_SOF_ONES,
    parameter int unsigned EOF_ZEROS = DEF_EOF_ZEROS,
    parameter int unsigned EOF_ONES  = DEF_EOF_ONES,
    parameter int unsigned PAD_ONES  = DEF_PAD_ONES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_tick,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd_byte,
    input  logic              cmd_last,
    output logic              cmd_ready,
    output logic              mod_out,
    output logic              frame_busy,
    output logic              frame_done
);

    logic              open_win;
    logic              take;
    logic              avail;
    logic [DATA_W-1:0] avail_byte;
    logic              avail_last;
    emit_t             emit;

    tbx_byte_stage #(
        .DATA_W (DATA_W)
    ) u_stage (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .cmd_last   (cmd_last),
        .cmd_ready  (cmd_ready),
        .open_win   (open_win),
        .take       (take),
        .avail      (avail),
        .avail_byte (avail_byte),
        .avail_last (avail_last)
    );

    tbx_bit_sequencer #(
        .DATA_W    (DATA_W),
        .SOF_ZEROS (SOF_ZEROS),
        .SOF_ONES  (SOF_ONES),
        .EOF_ZEROS (EOF_ZEROS),
        .EOF_ONES  (EOF_ONES),
        .PAD_ONES  (PAD_ONES)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .avail      (avail),
        .avail_byte (avail_byte),
        .avail_last (avail_last),
        .open_win   (open_win),
        .take       (take),
        .emit       (emit),
        .frame_busy (frame_busy)
    );

    tbx_line_drive u_line (
        .clk        (clk),
        .rst        (rst),
        .emit       (emit),
        .mod_out    (mod_out),
        .frame_done (frame_done)
    );

    // R1: outside a frame the carrier is left on
    p_idle_carrier_r1 : assert property (@(posedge clk) disable iff (rst)
        !frame_busy |-> (mod_out == 1'b0))
        else $error("p_idle_carrier_r1");

    // R11: the line holds between ticks
    p_line_holds_r11 : assert property (@(posedge clk) disable iff (rst)
        !$past(bit_tick) |-> $stable(mod_out))
        else $error("p_line_holds_r11");

    // R6: a closed byte window only reopens at a tick
    p_ready_on_tick_r6 : assert property (@(posedge clk) disable iff (rst)
        (!cmd_ready && !bit_tick) |=> !cmd_ready)
        else $error("p_ready_on_tick_r6");

endmodule

// File: tb/tbx_frame_serializer_tb_top.sv
module tbx_frame_serializer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BIT_DIV    = 4;
    localparam int WATCHDOG   = 100000;

    typedef struct {
        logic mod;
        logic rdy;
        int   req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   gap_seen = 0;
    bit   await_done = 1'b0;
    bit   finished = 1'b0;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       cmd_last = 1'b0;
    logic       cmd_ready, mod_out, frame_busy, frame_done;

    int   div_cnt = 0;
    logic tick_last = 1'b0;
    logic mod_last = 1'b0;
    exp_t cur;

    always #(CLK_PERIOD/2) clk = ~clk;

    tbx_frame_serializer dut_i (
        .clk        (clk),
        .rst        (rst),
        .bit_tick   (bit_tick),
        .cmd_valid  (cmd_valid),
        .cmd_byte   (cmd_byte),
        .cmd_last   (cmd_last),
        .cmd_ready  (cmd_ready),
        .mod_out    (mod_out),
        .frame_busy (frame_busy),
        .frame_done (frame_done)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // Expected output for one logical bit (R2: mod_out is its inverse)
    function automatic void push_bit(logic lvl, logic rdy, int req);
        exp_t e;
        e.mod = ~lvl;
        e.rdy = rdy;
        e.req = req;
        exp_q.push_back(e);
    endfunction

    // R3: ten zeros then two ones, window closed
    function automatic void push_sof();
        for (int i = 0; i < 10; i++) push_bit(1'b0, 1'b0, 3);
        for (int i = 0; i < 2; i++)  push_bit(1'b1, 1'b0, 3);
    endfunction

    // R4: start, data LSB first, stop; R6: window open on a non-last stop bit
    function automatic void push_char(logic [7:0] b, bit last);
        push_bit(1'b0, 1'b0, 4);
        for (int i = 0; i < 8; i++) push_bit(b[i], 1'b0, 4);
        push_bit(1'b1, !last, 6);
    endfunction

    // R8: ten zeros and a one; R9: eight ones
    function automatic void push_tail();
        for (int i = 0; i < 10; i++) push_bit(1'b0, 1'b0, 8);
        push_bit(1'b1, 1'b0, 8);
        for (int i = 0; i < 8; i++) push_bit(1'b1, 1'b0, 9);
    endfunction

    // Monitor plus tick generator in one process so the order is fixed
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (tick_last) begin
                if (exp_q.size() > 0) begin
                    cur = exp_q.pop_front();
                    check($sformatf("R%0d", cur.req), "mod_out", {31'b0, mod_out}, {31'b0, cur.mod});
                    check("R6", "cmd_ready", {31'b0, cmd_ready}, {31'b0, cur.rdy});
                    check("R10", "frame_done mid-frame", {31'b0, frame_done}, 32'd0);
                end else if (await_done) begin
                    check("R10", "frame_done", {31'b0, frame_done}, 32'd1);
                    check("R10", "frame_busy at done", {31'b0, frame_busy}, 32'd0);
                    check("R1", "mod_out after frame", {31'b0, mod_out}, 32'd0);
                    await_done = 1'b0;
                end else if (frame_busy) begin
                    // R7: rest level while waiting for a late byte
                    check("R7", "gap mod_out", {31'b0, mod_out}, 32'd0);
                    check("R6", "gap cmd_ready", {31'b0, cmd_ready}, 32'd1);
                    gap_seen++;
                end
            end else begin
                check("R11", "mod_out between ticks", {31'b0, mod_out}, {31'b0, mod_last});
            end
            mod_last = mod_out;
        end
        div_cnt   = (div_cnt + 1) % BIT_DIV;
        bit_tick  = (div_cnt == 0);
        tick_last = bit_tick;
    end

    task automatic send_frame(input logic [7:0] bytes[$], input int gap_idx, input int gap_bits);
        for (int i = 0; i < bytes.size(); i++) begin
            if (i == gap_idx) begin
                while (!cmd_ready) @(negedge clk);
                repeat (gap_bits * BIT_DIV) @(negedge clk);
            end
            cmd_valid = 1'b1;
            cmd_byte  = bytes[i];
            cmd_last  = (i == bytes.size() - 1);
            while (!cmd_ready) @(negedge clk);
            @(posedge clk);
            #1;
            if (i == 0) push_sof();
            push_char(bytes[i], i == bytes.size() - 1);
            if (i == bytes.size() - 1) begin
                push_tail();
                await_done = 1'b1;
            end
            @(negedge clk);
            cmd_valid = 1'b0;
            cmd_last  = 1'b0;
        end
        while (await_done) @(negedge clk);
        check("R9", "expected bits left", exp_q.size(), 32'd0);
        repeat (2 * BIT_DIV) @(negedge clk);
        check("R1", "frame_busy between frames", {31'b0, frame_busy}, 32'd0);
        check("R1", "cmd_ready between frames", {31'b0, cmd_ready}, 32'd1);
    endtask

    initial begin
        logic [7:0] f[$];
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "mod_out after reset", {31'b0, mod_out}, 32'd0);
        check("R1", "cmd_ready after reset", {31'b0, cmd_ready}, 32'd1);
        check("R1", "frame_busy after reset", {31'b0, frame_busy}, 32'd0);
        check("R1", "frame_done after reset", {31'b0, frame_done}, 32'd0);

        // R3 R4 R8 R9 R10: single character frame
        f = '{8'hA5};
        send_frame(f, -1, 0);

        // R5: back-to-back characters, edge data values
        f = '{8'h01, 8'h80, 8'hFF};
        send_frame(f, -1, 0);

        // R7: late second byte produces rest-level bits
        gap_seen = 0;
        f = '{8'h3C, 8'h00, 8'hC3};
        send_frame(f, 1, 5);
        check("R7", "gap bits observed", {31'b0, gap_seen > 0}, 32'd1);

        // R2: an all-zero byte, offset in tick phase
        @(negedge clk);
        f = '{8'h00};
        send_frame(f, -1, 0);

        f = '{8'h5A, 8'h96};
        @(negedge clk);
        @(negedge clk);
        send_frame(f, -1, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected frame completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule